// File: doc/BRIEF.md
# Adaptive TDMA Slot Timer

This block keeps slot time for a TDMA radio node whose tick clock comes from a cheap on-chip oscillator with large frequency error. It counts ticks to mark slot and slot-frame boundaries. It keeps an absolute slot number that runs for the whole life of the network. Inside each slot it raises a transmit strobe at a fixed offset.

When a packet from the time parent starts arriving, the radio pulses a packet-start strobe. The block stamps that strobe with the tick position inside the slot. The signed distance from the nominal transmit offset is the synchronization error. The slot phase is then snapped into line with the parent.

The sign of each error moves a signed direction counter. The errors themselves go into a small circular history. When the counter's magnitude reaches the threshold, the slot length is corrected by the mean of the stored errors, spread over the slots of one frame. The transmit offset is then re-derived from the new length at a fixed ratio. In this way the node follows both phase error and frequency drift.

Top module: `slot_sync_timer`

## Requirements
- R1: After reset the slot length is 50 ticks and the first `slot_strobe` comes 50 cycles after reset is released. From then on a one-cycle `slot_strobe` comes every `slot_duration` cycles while no sync event occurs.
- R2: `tx_fire` pulses once per slot, exactly `tx_offset` cycles after that slot's `slot_strobe`.
- R3: A sync event is `pkt_start` high together with `sync_valid` high on a clock edge while `is_master` is low. On that edge `sync_error` takes the signed value (tick position at that edge) minus `tx_offset`. Tick position 0 is the cycle in which `slot_strobe` is high.
- R4: `frame_strobe` is high together with every 4th `slot_strobe`, starting from reset: slot numbers 4, 8, 12 and so on.
- R5: `asn` is 0 after reset. It rises by exactly 1 with each `slot_strobe`, holds at all other times, and does not wrap at frame boundaries.
- R6: A sync event sets the tick position to `tx_offset`+1, so the next `slot_strobe` comes `slot_duration`-`tx_offset`-1 cycles later. A slot end that coincides with a sync event is deferred, never skipped or doubled.
- R7: A signed direction counter moves by +1 for a positive error and by -1 for a negative error, and stays put for a zero error. When it reaches a magnitude of 20 it clears and a slot-length correction is triggered.
- R8: One cycle after the triggering sync event, `slot_duration` grows by (mean of the last 8 stored errors, truncated toward zero) divided by 4 (the slots per frame), also truncated toward zero. `slot_duration` changes at no other time except on a load.
- R9: Whenever `slot_duration` is set (by reset, load or correction), `tx_offset` becomes `slot_duration`/5, truncated.
- R10: With `is_master` high or `sync_valid` low, `pkt_start` is ignored. `sync_error`, the slot phase and the direction counter are left unchanged.
- R11: `load_en` sets `slot_duration` to `load_duration`. It also clears the direction counter and empties the error history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local tick clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | Node is the time master; sync events are ignored |
| load_en | input | 1 | Load an initial slot length and clear drift history |
| load_duration | input | 12 | Slot length in ticks to load |
| pkt_start | input | 1 | Radio strobe: a received packet is starting |
| sync_valid | input | 1 | Qualifies `pkt_start` as coming from the time parent |
| slot_strobe | output | 1 | One-cycle pulse at each slot start |
| frame_strobe | output | 1 | One-cycle pulse at each slot-frame start |
| tx_fire | output | 1 | One-cycle pulse at the transmit offset inside a slot |
| sync_error | output | 13 | Signed error of the last sync event, in ticks |
| slot_duration | output | 12 | Current slot length in ticks |
| tx_offset | output | 12 | Current transmit offset in ticks |
| asn | output | 32 | Absolute slot number |

## Verification
The bench fires a packet on the very last tick of a slot. A design that let the boundary logic win would either skip a slot number or emit an extra strobe. A run of twelve large errors followed by eight small ones checks the history: a design that averaged every error ever seen, rather than the last eight, would lengthen the slot by 3 instead of 1. Negative errors whose mean does not divide evenly catch rounding toward minus infinity, which yields 48 instead of 49. Mixed-sign bursts and a load in the middle of a burst catch a counter that tracks magnitude only or survives the load, since either would trigger a correction that must not happen.

// File: rtl/slot_sync_pkg.sv
package slot_sync_pkg;

  // Transmit offset derived from a slot length at a fixed ratio.
  function automatic int offset_for(input int dur, input int ratio);
    return dur / ratio;
  endfunction

endpackage

// File: rtl/slot_tick_counter.sv
module slot_tick_counter #(
  parameter int DUR_W = 12,
  parameter int ASN_W = 32,
  parameter int SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DUR_W-1:0] dur,
  input  logic [DUR_W-1:0] offset,
  input  logic             sync_evt,
  output logic [DUR_W-1:0] tick_cnt,
  output logic             slot_strobe,
  output logic             frame_strobe,
  output logic             tx_fire,
  output logic [ASN_W-1:0] asn
);
  localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SLOTS - 1);

  logic [DUR_W-1:0] tick_inc;
  logic [DUR_W-1:0] realign;
  logic [IDX_W-1:0] idx_q;
  logic             slot_end;

  assign tick_inc = tick_cnt + 1'b1;
  assign slot_end = (tick_cnt >= dur - 1'b1);
  // Phase snaps to just past the transmit offset; if that would pass the
  // slot end, hold at the last tick so the boundary still fires next.
  assign realign  = (offset + 1'b1 < dur) ? offset + 1'b1 : dur - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_cnt     <= '0;
      idx_q        <= '0;
      asn          <= '0;
      slot_strobe  <= 1'b0;
      frame_strobe <= 1'b0;
      tx_fire      <= 1'b0;
    end else begin
      slot_strobe  <= 1'b0;
      frame_strobe <= 1'b0;
      tx_fire      <= 1'b0;
      if (sync_evt) begin
        tick_cnt <= realign;
      end else if (slot_end) begin
        tick_cnt     <= '0;
        slot_strobe  <= 1'b1;
        asn          <= asn + 1'b1;
        frame_strobe <= (idx_q == LAST_IDX);
        idx_q        <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        tx_fire      <= (offset == '0);
      end else begin
        tick_cnt <= tick_inc;
        tx_fire  <= (tick_inc == offset);
      end
    end
  end
endmodule

// File: rtl/err_history.sv
module err_history #(
  parameter int ERR_W = 13,
  parameter int DEPTH = 8,
  parameter int SUM_W = 17,
  parameter int HC_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    push,
  input  logic signed [ERR_W-1:0] err,
  output logic signed [SUM_W-1:0] sum,
  output logic [HC_W-1:0]         count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [HC_W-1:0]  FULL_CNT = HC_W'(DEPTH);

  logic signed [ERR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]        wp;
  logic                    full;
  logic signed [SUM_W-1:0] evicted;

  assign full    = (count == FULL_CNT);
  assign evicted = full ? SUM_W'(mem[wp]) : '0;

  // Storage without reset so it maps onto distributed RAM.
  always_ff @(posedge clk) begin
    if (push) mem[wp] <= err;
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wp    <= '0;
      count <= '0;
      sum   <= '0;
    end else if (push) begin
      wp    <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      count <= full ? count : count + 1'b1;
      sum   <= sum + SUM_W'(err) - evicted;
    end
  end
endmodule

// File: rtl/drift_tracker.sv
module drift_tracker #(
  parameter int DUR_W   = 12,
  parameter int ERR_W   = 13,
  parameter int SUM_W   = 17,
  parameter int HC_W    = 4,
  parameter int SC_W    = 6,
  parameter int SLOTS   = 4,
  parameter int THRESH  = 20,
  parameter int RATIO   = 5,
  parameter int DEF_DUR = 50,
  parameter int MIN_DUR = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sync_evt,
  input  logic signed [ERR_W-1:0] err,
  input  logic signed [SUM_W-1:0] sum,
  input  logic [HC_W-1:0]         count,
  input  logic                    load_en,
  input  logic [DUR_W-1:0]        load_dur,
  output logic [DUR_W-1:0]        dur,
  output logic [DUR_W-1:0]        offset,
  output logic signed [SC_W-1:0]  sync_cnt,
  output logic                    adj_pending
);
  localparam logic [DUR_W-1:0] DEF_OFF = DUR_W'(slot_sync_pkg::offset_for(DEF_DUR, RATIO));
  localparam logic signed [SC_W-1:0] POS_LIM = SC_W'(THRESH);
  localparam logic signed [SC_W-1:0] NEG_LIM = -POS_LIM;
  localparam int MAX_DUR = (1 << DUR_W) - 1;

  logic signed [SC_W-1:0] cnt_next;
  logic                   hit;
  logic signed [31:0]     avg, corr, nd;

  always_comb begin
    if (!err[ERR_W-1] && err != '0) cnt_next = sync_cnt + SC_W'(1);
    else if (err[ERR_W-1])          cnt_next = sync_cnt - SC_W'(1);
    else                            cnt_next = sync_cnt;
    hit = (cnt_next >= POS_LIM) || (cnt_next <= NEG_LIM);
  end

  always_comb begin
    avg  = (count == '0) ? 32'sd0 : 32'(sum) / $signed(32'(count));
    corr = avg / SLOTS;
    nd   = $signed(32'(dur)) + corr;
    if (nd < MIN_DUR) nd = MIN_DUR;
    if (nd > MAX_DUR) nd = MAX_DUR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dur         <= DUR_W'(DEF_DUR);
      offset      <= DEF_OFF;
      sync_cnt    <= '0;
      adj_pending <= 1'b0;
    end else if (load_en) begin
      dur         <= load_dur;
      offset      <= load_dur / DUR_W'(RATIO);
      sync_cnt    <= '0;
      adj_pending <= 1'b0;
    end else begin
      if (adj_pending) begin
        dur         <= DUR_W'(nd);
        offset      <= DUR_W'(nd / RATIO);
        adj_pending <= 1'b0;
      end
      if (sync_evt) begin
        if (hit) begin
          sync_cnt    <= '0;
          adj_pending <= 1'b1;
        end else begin
          sync_cnt <= cnt_next;
        end
      end
    end
  end
endmodule

// File: rtl/slot_sync_timer.sv
module slot_sync_timer #(
  parameter int DUR_W   = 12,
  parameter int ASN_W   = 32,
  parameter int SLOTS   = 4,
  parameter int DEPTH   = 8,
  parameter int THRESH  = 20,
  parameter int RATIO   = 5,
  parameter int DEF_DUR = 50,
  parameter int MIN_DUR = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               is_master,
  input  logic               load_en,
  input  logic [DUR_W-1:0]   load_duration,
  input  logic               pkt_start,
  input  logic               sync_valid,
  output logic               slot_strobe,
  output logic               frame_strobe,
  output logic               tx_fire,
  output logic [DUR_W:0]     sync_error,
  output logic [DUR_W-1:0]   slot_duration,
  output logic [DUR_W-1:0]   tx_offset,
  output logic [ASN_W-1:0]   asn
);
  localparam int ERR_W = DUR_W + 1;
  localparam int SUM_W = ERR_W + $clog2(DEPTH) + 1;
  localparam int HC_W  = $clog2(DEPTH + 1);
  localparam int SC_W  = $clog2(THRESH + 1) + 1;

  logic [DUR_W-1:0]        tick_cnt;
  logic                    sync_evt;
  logic signed [ERR_W-1:0] err_now;
  logic signed [SUM_W-1:0] err_sum;
  logic [HC_W-1:0]         err_count;
  logic signed [SC_W-1:0]  sync_cnt;
  logic                    adj_pending;

  assign sync_evt = pkt_start && sync_valid && !is_master && !load_en;
  assign err_now  = $signed({1'b0, tick_cnt}) - $signed({1'b0, tx_offset});

  always_ff @(posedge clk) begin
    if (rst)           sync_error <= '0;
    else if (sync_evt) sync_error <= err_now;
  end

  slot_tick_counter #(.DUR_W(DUR_W), .ASN_W(ASN_W), .SLOTS(SLOTS)) u_ticks (
    .clk(clk), .rst(rst), .dur(slot_duration), .offset(tx_offset),
    .sync_evt(sync_evt), .tick_cnt(tick_cnt), .slot_strobe(slot_strobe),
    .frame_strobe(frame_strobe), .tx_fire(tx_fire), .asn(asn)
  );

  err_history #(.ERR_W(ERR_W), .DEPTH(DEPTH), .SUM_W(SUM_W), .HC_W(HC_W)) u_hist (
    .clk(clk), .rst(rst), .clear(load_en), .push(sync_evt), .err(err_now),
    .sum(err_sum), .count(err_count)
  );

  drift_tracker #(
    .DUR_W(DUR_W), .ERR_W(ERR_W), .SUM_W(SUM_W), .HC_W(HC_W), .SC_W(SC_W),
    .SLOTS(SLOTS), .THRESH(THRESH), .RATIO(RATIO), .DEF_DUR(DEF_DUR), .MIN_DUR(MIN_DUR)
  ) u_drift (
    .clk(clk), .rst(rst), .sync_evt(sync_evt), .err(err_now), .sum(err_sum),
    .count(err_count), .load_en(load_en), .load_dur(load_duration),
    .dur(slot_duration), .offset(tx_offset), .sync_cnt(sync_cnt),
    .adj_pending(adj_pending)
  );
endmodule

// File: rtl/slot_sync_timer_chk.sv
module slot_sync_timer_chk #(
  parameter int DUR_W  = 12,
  parameter int ASN_W  = 32,
  parameter int THRESH = 20,
  parameter int SC_W   = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   is_master,
  input logic                   load_en,
  input logic                   sync_evt,
  input logic                   slot_strobe,
  input logic                   frame_strobe,
  input logic [DUR_W:0]         sync_error,
  input logic [DUR_W-1:0]       slot_duration,
  input logic [DUR_W-1:0]       tx_offset,
  input logic [DUR_W-1:0]       tick_cnt,
  input logic [ASN_W-1:0]       asn,
  input logic signed [SC_W-1:0] sync_cnt,
  input logic                   adj_pending
);
  localparam logic signed [SC_W-1:0] LIM = SC_W'(THRESH);

  assert_tick_range_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_cnt >= slot_duration) |-> ($past(adj_pending) || $past(load_en)));

  assert_frame_on_slot_R4: assert property (@(posedge clk) disable iff (rst)
    frame_strobe |-> slot_strobe);

  assert_asn_step_R5: assert property (@(posedge clk) disable iff (rst)
    slot_strobe |-> (asn == $past(asn) + ASN_W'(1)));

  assert_asn_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !slot_strobe |-> $stable(asn));

  assert_phase_realign_R6: assert property (@(posedge clk) disable iff (rst)
    (sync_evt && (tx_offset + 1'b1 < slot_duration)) |=> (tick_cnt == $past(tx_offset) + 1'b1));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    (sync_cnt < LIM) && (sync_cnt > -LIM));

  assert_dur_change_R8: assert property (@(posedge clk) disable iff (rst)
    !$stable(slot_duration) |-> ($past(adj_pending) || $past(load_en)));

  assert_master_ignores_R10: assert property (@(posedge clk) disable iff (rst)
    is_master |=> $stable(sync_error));
endmodule

bind slot_sync_timer slot_sync_timer_chk #(
  .DUR_W(DUR_W), .ASN_W(ASN_W), .THRESH(THRESH), .SC_W(SC_W)
) u_chk (
  .clk(clk), .rst(rst), .is_master(is_master), .load_en(load_en),
  .sync_evt(sync_evt), .slot_strobe(slot_strobe), .frame_strobe(frame_strobe),
  .sync_error(sync_error), .slot_duration(slot_duration), .tx_offset(tx_offset),
  .tick_cnt(tick_cnt), .asn(asn), .sync_cnt(sync_cnt), .adj_pending(adj_pending)
);

// File: tb/slot_sync_timer_tb.sv
module slot_sync_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        is_master = 1'b0;
  logic        load_en = 1'b0;
  logic [11:0] load_duration = '0;
  logic        pkt_start = 1'b0;
  logic        sync_valid = 1'b0;
  logic        slot_strobe, frame_strobe, tx_fire;
  logic [12:0] sync_error;
  logic [11:0] slot_duration, tx_offset;
  logic [31:0] asn;

  int checks = 0;
  int failures = 0;

  slot_sync_timer u_dut (
    .clk(clk), .rst(rst), .is_master(is_master), .load_en(load_en),
    .load_duration(load_duration), .pkt_start(pkt_start), .sync_valid(sync_valid),
    .slot_strobe(slot_strobe), .frame_strobe(frame_strobe), .tx_fire(tx_fire),
    .sync_error(sync_error), .slot_duration(slot_duration), .tx_offset(tx_offset),
    .asn(asn)
  );

  always #2.5ns clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (!slot_strobe);
  endtask

  task automatic gap_to_strobe(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!slot_strobe);
  endtask

  // Waits for a slot start, then t cycles, then presents one packet start.
  task automatic pulse(input int t, input bit valid, input bit master);
    wait_strobe();
    repeat (t) @(negedge clk);
    is_master = master; pkt_start = 1'b1; sync_valid = valid;
    @(negedge clk);
    is_master = 1'b0; pkt_start = 1'b0; sync_valid = 1'b0;
  endtask

  task automatic burst(input int n, input int t);
    for (int i = 0; i < n; i++) pulse(t, 1'b1, 1'b0);
  endtask

  task automatic load(input int d);
    @(negedge clk);
    load_en = 1'b1; load_duration = 12'(d);
    @(negedge clk);
    load_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    int a0;
    longint e0;
    repeat (4) @(negedge clk);
    // R11 reset values, R5 asn cleared
    check("R11 reset duration", slot_duration, 50);
    check("R9 reset offset", tx_offset, 10);
    check("R5 reset asn", asn, 0);
    check("R1 no strobe in reset", slot_strobe, 0);
    check("R3 reset error", $signed(sync_error), 0);
    rst = 1'b0;

    // R1 first period and steady period
    gap_to_strobe(n);
    check("R1 first slot length", n, 50);
    check("R5 asn after first slot", asn, 1);
    gap_to_strobe(n);
    check("R1 slot length", n, 50);
    // R2 transmit strobe position
    n = 0;
    do begin @(negedge clk); n++; end while (!tx_fire);
    check("R2 tx_fire offset", n, 10);
    // R4 frame strobe on slot 4 and 8
    do @(negedge clk); while (!frame_strobe);
    check("R4 first frame at asn", asn, 4);
    check("R4 frame with slot", slot_strobe, 1);
    do @(negedge clk); while (!frame_strobe);
    check("R4 second frame at asn", asn, 8);
    check("R5 asn no frame wrap", asn, 8);

    // R3 / R6 late packet
    pulse(30, 1'b1, 1'b0);
    check("R3 late error", $signed(sync_error), 20);
    gap_to_strobe(n);
    check("R6 realign after late", n, 39);
    // early packet
    pulse(3, 1'b1, 1'b0);
    check("R3 early error", $signed(sync_error), -7);
    gap_to_strobe(n);
    check("R6 realign after early", n, 39);
    // packet on the last tick of a slot
    pulse(49, 1'b1, 1'b0);
    a0 = int'(asn);
    check("R3 last tick error", $signed(sync_error), 39);
    gap_to_strobe(n);
    check("R6 deferred boundary gap", n, 39);
    check("R6 no skipped slot", asn, a0 + 1);

    // R10 master and unqualified packets ignored
    e0 = $signed(sync_error);
    pulse(30, 1'b1, 1'b1);
    check("R10 master error held", $signed(sync_error), e0);
    gap_to_strobe(n);
    check("R10 master phase held", n, 19);
    pulse(30, 1'b0, 1'b0);
    check("R10 invalid error held", $signed(sync_error), e0);
    gap_to_strobe(n);
    check("R10 invalid phase held", n, 19);

    // R7 / R8 / R9 positive drift
    load(50);
    burst(19, 18);
    check("R7 no correction before 20", slot_duration, 50);
    burst(1, 18);
    @(negedge clk);
    check("R8 positive correction", slot_duration, 52);
    check("R9 offset after +2", tx_offset, 10);

    // R8 circular history keeps last 8 only
    load(50);
    burst(12, 30);
    burst(8, 14);
    @(negedge clk);
    check("R8 last eight averaged", slot_duration, 51);

    // R8 negative, truncation toward zero
    load(50);
    burst(20, 4);
    @(negedge clk);
    check("R8 negative correction", slot_duration, 49);
    check("R9 offset after shrink", tx_offset, 9);

    // R7 opposite signs cancel
    load(50);
    burst(10, 18);
    burst(10, 4);
    @(negedge clk);
    check("R7 mixed signs no correction", slot_duration, 50);

    // R11 load clears the counter
    load(50);
    burst(19, 18);
    load(50);
    burst(1, 18);
    @(negedge clk);
    check("R11 counter cleared by load", slot_duration, 50);
    burst(19, 18);
    @(negedge clk);
    check("R11 count restarts after load", slot_duration, 52);

    // R11 load value and R1 period follows it
    load(60);
    check("R11 loaded duration", slot_duration, 60);
    check("R9 loaded offset", tx_offset, 12);
    wait_strobe();
    gap_to_strobe(n);
    check("R1 loaded slot length", n, 60);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule